// File: doc/BRIEF.md
# Accumulator Mini-Processor Core

This block is a small single-cycle processor built around one 8-bit accumulator. It has a 16-word program store that is fixed when the block is built. It also has a 16-entry scratch register file, an extension register that takes the upper or remainder half of multiply and divide results, and a single carry/borrow flag.

Each instruction word is 8 bits. The upper nibble selects the operation. The lower nibble names a scratch register or a jump target. Opcode zero instead uses its lower nibble to pick an operation that works on the accumulator alone.

Each clock edge with the core running fetches the word at the program counter, executes it and moves the counter on. A pause input freezes every piece of architectural state. A halt word parks the core until the next reset. The program counter, the last fetched word, the accumulator, the extension register, the flag and the halted status are all visible as outputs.

The program is set through the `PROGRAM` parameter. Word 0 sits in the lowest 8 bits.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low (asynchronous), `pc`, `ir`, `acc`, `ext`, `cb_flag` and `halted` read zero, and every scratch register is cleared to zero.
- R2: On each rising edge with `pause` low and the core not halted, the word at `pc` is latched into `ir` and executed. Unless it branches or halts, `pc` becomes `pc+1` and wraps from 15 to 0. Word 0x00 changes nothing else.
- R3: On a rising edge with `pause` high, `pc`, `ir`, `acc`, `ext`, `cb_flag`, `halted` and the scratch registers keep their values.
- R4: Opcode 0x1 (add Rn) sets `acc` to the low 8 bits of `acc+Rn` and `cb_flag` to the carry out. Opcode 0x2 (subtract Rn) sets `acc` to `acc-Rn` modulo 256 and `cb_flag` to 1 exactly when `acc<Rn`. Opcode 0x7 (compare Rn) sets only `cb_flag`, with the same rule as subtract.
- R5: Opcode 0x3 (multiply Rn) puts the low byte of the 16-bit product in `acc` and the high byte in `ext`. Opcode 0x4 (divide by Rn) puts the quotient in `acc` and the remainder in `ext`. When Rn is zero, `acc` becomes 0xFF and `ext` takes the old `acc`. None of these touch `cb_flag`.
- R6: Opcodes 0x5 (AND Rn) and 0x6 (XOR Rn) combine `acc` bitwise with Rn. Words 0x01..0x05 act on `acc` alone: 0x01 shifts left logically, 0x02 shifts right logically, 0x03 rotates right, 0x04 rotates left, and 0x05 shifts right arithmetically. None of these change `cb_flag`.
- R7: Word 0x06 increments `acc` and sets `cb_flag` to 1 only when `acc` wraps from 0xFF to 0x00. Word 0x07 decrements `acc` and sets `cb_flag` to 1 only when it wraps from 0x00 to 0xFF.
- R8: Opcode 0x8 loads `pc` with its low nibble when `cb_flag` is 1 and otherwise increments `pc`. Opcode 0xB loads `pc` with its low nibble unconditionally.
- R9: Opcode 0x9 copies Rn into `acc`. Opcode 0xA copies `acc` into Rn.
- R10: Word 0xFF sets `halted` and leaves `pc` on the halt word. After that, no state changes until reset. Opcodes 0xC..0xE and words 0xF0..0xFE, like the unused words 0x08..0x0F, only advance `pc` and `ir`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pause | input | 1 | High freezes all architectural state |
| pc | output | 4 | Program counter (address of next word) |
| ir | output | 8 | Most recently executed instruction word |
| acc | output | 8 | Accumulator |
| ext | output | 8 | Extension register (product high byte or remainder) |
| cb_flag | output | 1 | Carry/borrow flag |
| halted | output | 1 | High once a halt word has executed |

## Verification
The only way to reach the scratch registers and the arithmetic corners is through the fixed program, so the bench builds two instances with different programs. One program runs divide by zero on a register that was never written, produces a borrow that makes a conditional branch taken, and later uses a compare that leaves the branch not taken. Its last word increments and falls through the counter wrap, so a second pass meets different data. The other program covers the logic operations, copies, a reserved opcode, an unconditional jump and the halt. A reference model in the bench steps both programs in lockstep while pause pulses and a mid-run reset are applied on top of them.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int unsigned WORD_W  = 8;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned OPC_W   = WORD_W - FIELD_W;
  localparam int unsigned DEPTH   = 1 << FIELD_W;
  localparam int unsigned PROD_W  = 2 * WORD_W;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;

  localparam word_t HALT_WORD = '1;

  typedef enum logic [OPC_W-1:0] {
    OP_IMPL = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_MUL  = 4'h3,
    OP_DIV  = 4'h4,
    OP_AND  = 4'h5,
    OP_XOR  = 4'h6,
    OP_CMP  = 4'h7,
    OP_BRC  = 4'h8,
    OP_LDA  = 4'h9,
    OP_STA  = 4'hA,
    OP_JMP  = 4'hB,
    OP_RSVC = 4'hC,
    OP_RSVD = 4'hD,
    OP_RSVE = 4'hE,
    OP_SYS  = 4'hF
  } opc_e;

  typedef enum logic [FIELD_W-1:0] {
    IM_NOP = 4'h0,
    IM_LSL = 4'h1,
    IM_LSR = 4'h2,
    IM_ROR = 4'h3,
    IM_ROL = 4'h4,
    IM_ASR = 4'h5,
    IM_INC = 4'h6,
    IM_DEC = 4'h7,
    IM_U8  = 4'h8,
    IM_U9  = 4'h9,
    IM_UA  = 4'hA,
    IM_UB  = 4'hB,
    IM_UC  = 4'hC,
    IM_UD  = 4'hD,
    IM_UE  = 4'hE,
    IM_UF  = 4'hF
  } impl_e;

  typedef struct packed {
    word_t acc;
    word_t ext;
    logic  flag;
  } alu_res_t;

  // carry out in the top bit
  function automatic logic [WORD_W:0] f_add(word_t a, word_t b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // borrow in the top bit (set when a < b)
  function automatic logic [WORD_W:0] f_sub(word_t a, word_t b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  function automatic logic [PROD_W-1:0] f_mul(word_t a, word_t b);
    return {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b};
  endfunction

  // {remainder, quotient}; zero divisor yields {a, all ones}
  function automatic logic [PROD_W-1:0] f_div(word_t a, word_t b);
    if (b == '0) return {a, {WORD_W{1'b1}}};
    return {word_t'(a % b), word_t'(a / b)};
  endfunction

  function automatic word_t f_shift(impl_e sel, word_t a);
    case (sel)
      IM_LSL:  return {a[WORD_W-2:0], 1'b0};
      IM_LSR:  return {1'b0, a[WORD_W-1:1]};
      IM_ROR:  return {a[0], a[WORD_W-1:1]};
      IM_ROL:  return {a[WORD_W-2:0], a[WORD_W-1]};
      IM_ASR:  return {a[WORD_W-1], a[WORD_W-1:1]};
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/acc_core_rom.sv
module acc_core_rom
  import acc_core_pkg::*;
#(
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
  input  field_t addr_i,
  output word_t  data_o
);

  word_t words_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words_w[g] = IMAGE[g*WORD_W +: WORD_W];
  end

  assign data_o = words_w[addr_i];

endmodule

// File: rtl/acc_core_regfile.sv
module acc_core_regfile
  import acc_core_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we_i,
  input  field_t waddr_i,
  input  word_t  wdata_i,
  input  field_t raddr_i,
  output word_t  rdata_o
);

  word_t regs_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (we_i && (waddr_i == field_t'(g))) begin
        regs_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = regs_q[raddr_i];

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
(
  input  opc_e     opc_i,
  input  field_t   fld_i,
  input  word_t    acc_i,
  input  word_t    ext_i,
  input  logic     flag_i,
  input  word_t    rval_i,
  output alu_res_t res_o,
  output logic     div_zero_o
);

  logic [WORD_W:0]   sum_w;
  logic [WORD_W:0]   dif_w;
  logic [WORD_W:0]   inc_w;
  logic [WORD_W:0]   dec_w;
  logic [PROD_W-1:0] prod_w;
  logic [PROD_W-1:0] qr_w;
  impl_e             sel_w;

  assign sum_w  = f_add(acc_i, rval_i);
  assign dif_w  = f_sub(acc_i, rval_i);
  assign inc_w  = f_add(acc_i, word_t'(1));
  assign dec_w  = f_sub(acc_i, word_t'(1));
  assign prod_w = f_mul(acc_i, rval_i);
  assign qr_w   = f_div(acc_i, rval_i);
  assign sel_w  = impl_e'(fld_i);

  assign div_zero_o = (opc_i == OP_DIV) && (rval_i == '0);

  always_comb begin
    res_o.acc  = acc_i;
    res_o.ext  = ext_i;
    res_o.flag = flag_i;
    case (opc_i)
      OP_IMPL: begin
        case (sel_w)
          IM_LSL, IM_LSR, IM_ROR, IM_ROL, IM_ASR:
            res_o.acc = f_shift(sel_w, acc_i);
          IM_INC: begin
            res_o.acc  = inc_w[WORD_W-1:0];
            res_o.flag = inc_w[WORD_W];
          end
          IM_DEC: begin
            res_o.acc  = dec_w[WORD_W-1:0];
            res_o.flag = dec_w[WORD_W];
          end
          default: ;
        endcase
      end
      OP_ADD: begin
        res_o.acc  = sum_w[WORD_W-1:0];
        res_o.flag = sum_w[WORD_W];
      end
      OP_SUB: begin
        res_o.acc  = dif_w[WORD_W-1:0];
        res_o.flag = dif_w[WORD_W];
      end
      OP_CMP: res_o.flag = dif_w[WORD_W];
      OP_MUL: begin
        res_o.acc = prod_w[WORD_W-1:0];
        res_o.ext = prod_w[PROD_W-1:WORD_W];
      end
      OP_DIV: begin
        res_o.acc = qr_w[WORD_W-1:0];
        res_o.ext = qr_w[PROD_W-1:WORD_W];
      end
      OP_AND: res_o.acc = acc_i & rval_i;
      OP_XOR: res_o.acc = acc_i ^ rval_i;
      OP_LDA: res_o.acc = rval_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_core_seq.sv
module acc_core_seq
  import acc_core_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pause,
  input  word_t  instr_i,
  input  logic   flag_i,
  output field_t pc_o,
  output word_t  ir_o,
  output logic   halted_o,
  output logic   exec_o,
  output logic   take_br_o,
  output logic   halt_hit_o,
  output field_t target_o
);

  field_t pc_q;
  field_t pc_d;
  word_t  ir_q;
  logic   halted_q;
  opc_e   opc_w;

  assign opc_w      = opc_e'(instr_i[WORD_W-1 -: OPC_W]);
  assign target_o   = instr_i[FIELD_W-1:0];
  assign exec_o     = !pause && !halted_q;
  assign halt_hit_o = exec_o && (instr_i == HALT_WORD);
  assign take_br_o  = exec_o && (((opc_w == OP_BRC) && flag_i) || (opc_w == OP_JMP));

  always_comb begin
    if (halt_hit_o)     pc_d = pc_q;
    else if (take_br_o) pc_d = target_o;
    else                pc_d = pc_q + field_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      halted_q <= 1'b0;
    end else if (exec_o) begin
      pc_q <= pc_d;
      ir_q <= instr_i;
      if (halt_hit_o) halted_q <= 1'b1;
    end
  end

  assign pc_o     = pc_q;
  assign ir_o     = ir_q;
  assign halted_o = halted_q;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter logic [DEPTH*WORD_W-1:0] PROGRAM = {HALT_WORD, {((DEPTH-1)*WORD_W){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause,
  output logic [FIELD_W-1:0] pc,
  output logic [WORD_W-1:0]  ir,
  output logic [WORD_W-1:0]  acc,
  output logic [WORD_W-1:0]  ext,
  output logic              cb_flag,
  output logic              halted
);

  word_t    instr_w;
  field_t   pc_w;
  word_t    ir_w;
  logic     halted_w;
  logic     exec_w;
  logic     take_br_w;
  logic     halt_hit_w;
  field_t   target_w;
  opc_e     opc_w;
  field_t   fld_w;
  word_t    rval_w;
  alu_res_t res_w;
  logic     div_op_zero_w;
  logic     div_zero_w;
  logic     store_w;

  word_t acc_q;
  word_t ext_q;
  logic  flag_q;

  assign opc_w      = opc_e'(instr_w[WORD_W-1 -: OPC_W]);
  assign fld_w      = instr_w[FIELD_W-1:0];
  assign store_w    = exec_w && (opc_w == OP_STA);
  assign div_zero_w = exec_w && div_op_zero_w;

  acc_core_rom #(.IMAGE(PROGRAM)) u_rom (
    .addr_i (pc_w),
    .data_o (instr_w)
  );

  acc_core_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pause      (pause),
    .instr_i    (instr_w),
    .flag_i     (flag_q),
    .pc_o       (pc_w),
    .ir_o       (ir_w),
    .halted_o   (halted_w),
    .exec_o     (exec_w),
    .take_br_o  (take_br_w),
    .halt_hit_o (halt_hit_w),
    .target_o   (target_w)
  );

  acc_core_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (store_w),
    .waddr_i (fld_w),
    .wdata_i (acc_q),
    .raddr_i (fld_w),
    .rdata_o (rval_w)
  );

  acc_core_alu u_alu (
    .opc_i      (opc_w),
    .fld_i      (fld_w),
    .acc_i      (acc_q),
    .ext_i      (ext_q),
    .flag_i     (flag_q),
    .rval_i     (rval_w),
    .res_o      (res_w),
    .div_zero_o (div_op_zero_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      ext_q  <= '0;
      flag_q <= 1'b0;
    end else if (exec_w) begin
      acc_q  <= res_w.acc;
      ext_q  <= res_w.ext;
      flag_q <= res_w.flag;
    end
  end

  assign pc      = pc_w;
  assign ir      = ir_w;
  assign acc     = acc_q;
  assign ext     = ext_q;
  assign cb_flag = flag_q;
  assign halted  = halted_w;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   pause,
  input field_t pc,
  input word_t  acc,
  input word_t  ext,
  input logic   flag,
  input logic   halted,
  input logic   exec,
  input logic   take_br,
  input logic   halt_hit,
  input field_t target,
  input logic   div_zero
);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (pc == '0 && acc == '0 && ext == '0 && !flag && !halted));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !take_br && !halt_hit) |=> (pc == field_t'($past(pc) + field_t'(1))));

  p_pause_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pause |=> ($stable(pc) && $stable(acc) && $stable(ext) && $stable(flag) && $stable(halted)));

  p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |=> (acc == '1 && ext == $past(acc)));

  p_branch_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_br |=> (pc == $past(target)));

  p_halt_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit |=> (halted && $stable(pc)));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(acc) && $stable(ext) && $stable(flag)));

endmodule

bind acc_core acc_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pause    (pause),
  .pc       (pc),
  .acc      (acc),
  .ext      (ext),
  .flag     (cb_flag),
  .halted   (halted),
  .exec     (exec_w),
  .take_br  (take_br_w),
  .halt_hit (halt_hit_w),
  .target   (target_w),
  .div_zero (div_zero_w)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;

  // word 0 in the lowest byte
  localparam logic [127:0] PROG_A = {
    8'h06, 8'h8A, 8'h72, 8'h03, 8'h00, 8'hFF, 8'h8C, 8'h21,
    8'h41, 8'h42, 8'h05, 8'h31, 8'h11, 8'h02, 8'hA1, 8'h07};
  localparam logic [127:0] PROG_B = {
    8'hFF, 8'h83, 8'h73, 8'h00, 8'hBD, 8'hC5, 8'h8F, 8'h93,
    8'h00, 8'h63, 8'h53, 8'h07, 8'hA3, 8'h04, 8'h01, 8'h06};
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pause = 1'b0;
  always #2ns clk = ~clk;

  logic [3:0] pc_a, pc_b;
  logic [7:0] ir_a, ir_b, acc_a, acc_b, ext_a, ext_b;
  logic       fl_a, fl_b, hl_a, hl_b;

  acc_core #(.PROGRAM(PROG_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .pause(pause), .pc(pc_a), .ir(ir_a),
    .acc(acc_a), .ext(ext_a), .cb_flag(fl_a), .halted(hl_a));

  acc_core #(.PROGRAM(PROG_B)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .pause(pause), .pc(pc_b), .ir(ir_b),
    .acc(acc_b), .ext(ext_b), .cb_flag(fl_b), .halted(hl_b));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int    prog [2][16];
  int    m_pc [2], m_ir [2], m_acc [2], m_ext [2], m_fl [2], m_hl [2];
  int    m_rf [2][16];
  string m_tag [2];

  task automatic model_reset(input int k);
    m_pc[k] = 0; m_ir[k] = 0; m_acc[k] = 0; m_ext[k] = 0; m_fl[k] = 0; m_hl[k] = 0;
    for (int i = 0; i < 16; i++) m_rf[k][i] = 0;
    m_tag[k] = "R1";
  endtask

  task automatic model_step(input int k);
    int w, op, n, a, r, t, nxt;
    if (m_hl[k] != 0) begin
      m_tag[k] = "R10";
      return;
    end
    w = prog[k][m_pc[k]];
    op = w / 16; n = w % 16; a = m_acc[k]; r = m_rf[k][n];
    nxt = (m_pc[k] + 1) % 16;
    m_ir[k] = w;
    m_tag[k] = "R2";
    case (op)
      0: begin
        case (n)
          1: begin m_acc[k] = (a * 2) % 256;                 m_tag[k] = "R6"; end
          2: begin m_acc[k] = a / 2;                         m_tag[k] = "R6"; end
          3: begin m_acc[k] = a / 2 + (a % 2) * 128;         m_tag[k] = "R6"; end
          4: begin m_acc[k] = (a * 2) % 256 + a / 128;       m_tag[k] = "R6"; end
          5: begin m_acc[k] = a / 2 + (a / 128) * 128;       m_tag[k] = "R6"; end
          6: begin m_fl[k] = (a == 255); m_acc[k] = (a + 1) % 256;   m_tag[k] = "R7"; end
          7: begin m_fl[k] = (a == 0);   m_acc[k] = (a + 255) % 256; m_tag[k] = "R7"; end
          default: ;
        endcase
      end
      1: begin t = a + r; m_acc[k] = t % 256; m_fl[k] = (t > 255); m_tag[k] = "R4"; end
      2: begin m_fl[k] = (a < r); m_acc[k] = (a - r + 256) % 256; m_tag[k] = "R4"; end
      3: begin t = a * r; m_acc[k] = t % 256; m_ext[k] = t / 256; m_tag[k] = "R5"; end
      4: begin
        if (r == 0) begin m_acc[k] = 255; m_ext[k] = a; end
        else begin m_acc[k] = a / r; m_ext[k] = a % r; end
        m_tag[k] = "R5";
      end
      5: begin m_acc[k] = a & r; m_tag[k] = "R6"; end
      6: begin m_acc[k] = a ^ r; m_tag[k] = "R6"; end
      7: begin m_fl[k] = (a < r); m_tag[k] = "R4"; end
      8: begin if (m_fl[k] != 0) nxt = n; m_tag[k] = "R8"; end
      9: begin m_acc[k] = r; m_tag[k] = "R9"; end
      10: begin m_rf[k][n] = a; m_tag[k] = "R9"; end
      11: begin nxt = n; m_tag[k] = "R8"; end
      15: begin
        if (w == 255) begin m_hl[k] = 1; nxt = m_pc[k]; end
        m_tag[k] = "R10";
      end
      default: m_tag[k] = "R10";
    endcase
    m_pc[k] = nxt;
  endtask

  task automatic check_one(input int k, input logic [3:0] pc_d, input logic [7:0] ir_d,
                           input logic [7:0] acc_d, input logic [7:0] ext_d,
                           input logic fl_d, input logic hl_d);
    n_cmp++;
    if (pc_d !== 4'(m_pc[k]) || ir_d !== 8'(m_ir[k]) || acc_d !== 8'(m_acc[k]) ||
        ext_d !== 8'(m_ext[k]) || fl_d !== 1'(m_fl[k]) || hl_d !== 1'(m_hl[k])) begin
      n_bad++;
      $display("FAIL %s dut%0d t=%0t: pc %h/%h ir %h/%h acc %h/%h ext %h/%h flag %b/%b halted %b/%b (actual/expected)",
               m_tag[k], k, $time, pc_d, 4'(m_pc[k]), ir_d, 8'(m_ir[k]), acc_d, 8'(m_acc[k]),
               ext_d, 8'(m_ext[k]), fl_d, 1'(m_fl[k]), hl_d, 1'(m_hl[k]));
    end
  endtask

  task automatic cycle(input logic r, input logic p);
    @(negedge clk);
    rst_n = r;
    pause = p;
    @(posedge clk);
    #1ns;
    for (int k = 0; k < 2; k++) begin
      if (!r) model_reset(k);
      else if (p) m_tag[k] = "R3";
      else model_step(k);
    end
    check_one(0, pc_a, ir_a, acc_a, ext_a, fl_a, hl_a);
    check_one(1, pc_b, ir_b, acc_b, ext_b, fl_b, hl_b);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      prog[0][i] = int'(PROG_A[i*8 +: 8]);
      prog[1][i] = int'(PROG_B[i*8 +: 8]);
    end
    model_reset(0);
    model_reset(1);
    // R1: state held at zero under reset
    repeat (3) cycle(1'b0, 1'b0);
    // R2..R10: both programs run from word 0
    repeat (12) cycle(1'b1, 1'b0);
    // R3: freeze mid-program
    repeat (3) cycle(1'b1, 1'b1);
    repeat (24) cycle(1'b1, 1'b0);
    // R1: reset in the middle of a run, then a fresh start
    repeat (2) cycle(1'b0, 1'b0);
    for (int i = 0; i < 60; i++) cycle(1'b1, (i % 7) == 3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule